// File: doc/BRIEF.md
# Flash Command and Suspend Controller

This block is the command decoder and status keeper of a flash device. A host writes single-byte commands, with an address, on a simple write strobe. The block runs a modelled program or block-erase operation whose length in cycles is set by parameters. It stores the result in a small on-chip word array. It keeps an 8-bit status word that the host reads back on the same read port as the array. The block also drives a busy indication that the board would use as an open-drain ready/busy line.

A running erase can be suspended, so the host can read or program other blocks. A program can itself be suspended, either on its own or while nested inside a suspended erase. A suspend takes effect a fixed number of cycles after it is requested. A resume continues the operation from the step where it stopped. An erase resume that arrives while a nested program is still running is held back until that program is done. Every program or erase is refused, and flagged in status, when the programming supply is not good or the target block is locked while write protection is active.

Top module: `flash_susp_ctrl`

## Requirements
- R1: After reset the read port is in array mode, the busy enable `sts_oe` is 0, and a status read returns 0x80.
- R2: Opcode 0x40 followed by a data write starts a program of that byte at that address. `sts_oe` is 1 for exactly PROG_CYC cycles, the byte is then readable, and status is 0x80.
- R3: Opcode 0x20 followed by 0xD0 erases the addressed block: every word of that block reads 0xFF afterwards, and other blocks keep their contents.
- R4: Opcode 0xB0 during an erase sets status bit 7 (ready) and bit 6 (erase suspended); status reads 0xC0 exactly SUSP_LAT+1 cycles after the command edge, and `sts_oe` is then 0.
- R5: Opcode 0xB0 during a program gives status 0x84 (bits 7 and 2) exactly SUSP_LAT+1 cycles after the command edge. No array write happens while the program is suspended, and after resume the byte is written.
- R6: While an erase is suspended, only 0xFF, 0x70, 0x40 and 0xD0 are accepted. Other opcodes are ignored. An array read inside the suspended block returns status. A program aimed at the suspended block is dropped.
- R7: A program started during an erase suspend reads status 0x40 (bit 7 at 0, bit 6 at 1) while it runs. Only one operation advances at a time.
- R8: An 0xD0 written while the nested program runs keeps bit 6 at 1 until that program has finished. The erase restarts only after that.
- R9: On resume, status bits 7 and 6 (erase) or bits 7 and 2 (program) clear, `sts_oe` returns to 1, and the operation continues from its frozen point to a correct result.
- R10: While a program is suspended, only 0xFF, 0x70 and 0xD0 are accepted. An array read of the suspended address returns status, and reads elsewhere return array data.
- R11: A program with `vpp_ok` low sets status bits 3 and 4 (status 0x98) and leaves the array unchanged.
- R12: A program or erase on a block whose `lock_bits` bit is 1 while `wp_n` is 0 sets status bits 1 and 4 (0x92) and changes nothing. With `wp_n` at 1 the same program succeeds.
- R13: Opcode 0x50, when idle, clears status bits 1, 3, 4 and 5.
- R14: Opcode 0x20 followed by anything other than 0xD0 sets status bits 4 and 5 (0xB0) and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command/data write strobe, one cycle per write |
| cmd_data | input | 8 | Opcode or program data |
| cmd_addr | input | ADDR_W | Word address; top BLK_BITS bits select the block |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Array word or status, one cycle after the address |
| vpp_ok | input | 1 | Programming supply good |
| wp_n | input | 1 | Write protect, active low |
| lock_bits | input | 2**BLK_BITS | Per-block lock flags |
| sts_oe | output | 1 | Busy: 1 while the ready/busy line is driven low |

## Verification
`rd_data` and `sts_oe` are both registered once. A status change caused by a command sampled on edge S is therefore visible on the read port one edge later, and the bench samples on falling edges with that extra edge counted. The suspend latency is measured edge by edge from the 0xB0 write to the first 0xC0 or 0x84 and must equal SUSP_LAT+1. The busy window of a program is counted on `sts_oe` and must equal PROG_CYC. Completion-dependent results are polled on status bit 7 with a bound, while the timing-sensitive nested sequence is checked on fixed edges after each write.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int BYTE_W = 8;

  localparam logic [7:0] OP_READ_ARR = 8'hFF;
  localparam logic [7:0] OP_READ_SR  = 8'h70;
  localparam logic [7:0] OP_CLR_SR   = 8'h50;
  localparam logic [7:0] OP_ERASE    = 8'h20;
  localparam logic [7:0] OP_CONFIRM  = 8'hD0;
  localparam logic [7:0] OP_PROGRAM  = 8'h40;
  localparam logic [7:0] OP_SUSPEND  = 8'hB0;

  // status bit positions
  localparam int SB_READY = 7;
  localparam int SB_ESUSP = 6;
  localparam int SB_EFAIL = 5;
  localparam int SB_PFAIL = 4;
  localparam int SB_VPP   = 3;
  localparam int SB_PSUSP = 2;
  localparam int SB_LOCK  = 1;

  localparam logic [7:0] ERR_CLR_MASK = 8'h3A;

  typedef enum logic [1:0] {T_IDLE, T_RUN, T_DRAIN, T_SUSP} tmr_st_t;
  typedef enum logic [1:0] {CS_IDLE, CS_ESETUP, CS_PSETUP} cmd_st_t;
endpackage

// File: rtl/fsc_op_timer.sv
module fsc_op_timer
  import fsc_pkg::*;
#(
  parameter int CNT_W    = 6,
  parameter int SUSP_LAT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] load,
  input  logic             susp_req,
  input  logic             resume,
  output logic             busy,
  output logic             can_susp,
  output logic             susp,
  output logic             tick,
  output logic [CNT_W-1:0] cnt
);
  localparam int LAT_W = $clog2(SUSP_LAT + 1);

  tmr_st_t          st_q;
  logic [LAT_W-1:0] lat_q;

  always_comb begin
    busy     = (st_q == T_RUN) || (st_q == T_DRAIN);
    can_susp = (st_q == T_RUN);
    susp     = (st_q == T_SUSP);
    tick     = busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= T_IDLE;
      cnt   <= '0;
      lat_q <= '0;
    end else begin
      case (st_q)
        T_IDLE: begin
          if (start) begin
            st_q <= T_RUN;
            cnt  <= load;
          end
        end
        T_RUN: begin
          if (cnt == '0) begin
            st_q <= T_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
            if (susp_req) begin
              st_q  <= T_DRAIN;
              lat_q <= LAT_W'(SUSP_LAT - 1);
            end
          end
        end
        T_DRAIN: begin
          if (cnt == '0) begin
            st_q <= T_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
            if (lat_q == '0) st_q <= T_SUSP;
            else             lat_q <= lat_q - 1'b1;
          end
        end
        default: begin
          if (resume) st_q <= T_RUN;
        end
      endcase
    end
  end
endmodule

// File: rtl/fsc_array.sv
module fsc_array #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/flash_susp_ctrl.sv
module flash_susp_ctrl
  import fsc_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int BLK_BITS  = 2,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 40,
  parameter int SUSP_LAT  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cmd_we,
  input  logic [7:0]               cmd_data,
  input  logic [ADDR_W-1:0]        cmd_addr,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [7:0]               rd_data,
  input  logic                     vpp_ok,
  input  logic                     wp_n,
  input  logic [(1<<BLK_BITS)-1:0] lock_bits,
  output logic                     sts_oe
);
  localparam int OFF_W     = ADDR_W - BLK_BITS;
  localparam int BLK_WORDS = 1 << OFF_W;
  localparam int MAX_CYC   = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W     = $clog2(MAX_CYC + 1) + 1;

  // engine handshakes
  logic             e_busy, e_can, e_susp, e_tick;
  logic             p_busy, p_can, p_susp, p_tick;
  logic [CNT_W-1:0] e_cnt, p_cnt;
  logic             start_e, start_p, sreq_e, sreq_p, res_e, res_p;

  // command decode outputs
  logic             eres_req, clr_err, to_arr, to_sr;
  logic [7:0]       set_err;
  cmd_st_t          cs_q, cs_nxt;

  // held context
  logic [ADDR_W-1:0]   paddr_q;
  logic [7:0]          pdata_q;
  logic [BLK_BITS-1:0] eblk_q;
  logic [7:0]          err_q;
  logic                mode_sr_q;
  logic                eres_pend_q;

  logic [BLK_BITS-1:0] blk_in, rd_blk;
  logic                lock_hit, any_busy;
  logic [7:0]          sr;

  // array port
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [7:0]        mem_wdata, arr_q;
  logic              show_sr, show_q;
  logic [7:0]        sr_q;

  assign blk_in   = cmd_addr[ADDR_W-1 -: BLK_BITS];
  assign rd_blk   = rd_addr[ADDR_W-1 -: BLK_BITS];
  assign lock_hit = lock_bits[blk_in] && !wp_n;
  assign any_busy = e_busy || p_busy;

  always_comb begin
    start_e  = 1'b0;
    start_p  = 1'b0;
    sreq_e   = 1'b0;
    sreq_p   = 1'b0;
    res_p    = 1'b0;
    eres_req = 1'b0;
    clr_err  = 1'b0;
    to_arr   = 1'b0;
    to_sr    = 1'b0;
    set_err  = '0;
    cs_nxt   = cs_q;
    if (cmd_we) begin
      if (cs_q == CS_PSETUP) begin
        cs_nxt = CS_IDLE;
        to_sr  = 1'b1;
        if (!vpp_ok) begin
          set_err[SB_VPP]   = 1'b1;
          set_err[SB_PFAIL] = 1'b1;
        end else if (lock_hit) begin
          set_err[SB_LOCK]  = 1'b1;
          set_err[SB_PFAIL] = 1'b1;
        end else if (!(e_susp && (blk_in == eblk_q))) begin
          start_p = 1'b1;
        end
      end else if (cs_q == CS_ESETUP) begin
        cs_nxt = CS_IDLE;
        to_sr  = 1'b1;
        if (cmd_data != OP_CONFIRM) begin
          set_err[SB_PFAIL] = 1'b1;
          set_err[SB_EFAIL] = 1'b1;
        end else if (!vpp_ok) begin
          set_err[SB_VPP]   = 1'b1;
          set_err[SB_EFAIL] = 1'b1;
        end else if (lock_hit) begin
          set_err[SB_LOCK]  = 1'b1;
          set_err[SB_PFAIL] = 1'b1;
        end else begin
          start_e = 1'b1;
        end
      end else if (p_susp) begin
        case (cmd_data)
          OP_READ_ARR: to_arr = 1'b1;
          OP_READ_SR:  to_sr  = 1'b1;
          OP_CONFIRM:  begin res_p = 1'b1; to_sr = 1'b1; end
          default:     ;
        endcase
      end else if (any_busy) begin
        case (cmd_data)
          OP_READ_SR: to_sr = 1'b1;
          OP_SUSPEND: begin
            to_sr = 1'b1;
            if (p_can)      sreq_p = 1'b1;
            else if (e_can) sreq_e = 1'b1;
          end
          OP_CONFIRM: if (e_susp) eres_req = 1'b1;
          default: ;
        endcase
      end else if (e_susp) begin
        case (cmd_data)
          OP_READ_ARR: to_arr = 1'b1;
          OP_READ_SR:  to_sr  = 1'b1;
          OP_PROGRAM:  cs_nxt = CS_PSETUP;
          OP_CONFIRM:  begin eres_req = 1'b1; to_sr = 1'b1; end
          default:     ;
        endcase
      end else begin
        case (cmd_data)
          OP_READ_ARR: to_arr  = 1'b1;
          OP_READ_SR:  to_sr   = 1'b1;
          OP_CLR_SR:   clr_err = 1'b1;
          OP_ERASE:    cs_nxt  = CS_ESETUP;
          OP_PROGRAM:  cs_nxt  = CS_PSETUP;
          default:     ;
        endcase
      end
    end
  end

  // erase resume waits for any nested program to leave the picture
  assign res_e = e_susp && !p_busy && !p_susp && (eres_req || eres_pend_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q        <= CS_IDLE;
      paddr_q     <= '0;
      pdata_q     <= '0;
      eblk_q      <= '0;
      err_q       <= '0;
      mode_sr_q   <= 1'b0;
      eres_pend_q <= 1'b0;
      sts_oe      <= 1'b0;
    end else begin
      cs_q        <= cs_nxt;
      eres_pend_q <= (eres_pend_q || eres_req) && !res_e;
      sts_oe      <= any_busy;
      if (start_p) begin
        paddr_q <= cmd_addr;
        pdata_q <= cmd_data;
      end
      if (start_e) eblk_q <= blk_in;
      if (clr_err) err_q <= err_q & ~ERR_CLR_MASK;
      else         err_q <= err_q | set_err;
      if (to_arr)     mode_sr_q <= 1'b0;
      else if (to_sr) mode_sr_q <= 1'b1;
    end
  end

  assign sr = {~any_busy, e_susp, err_q[SB_EFAIL], err_q[SB_PFAIL],
               err_q[SB_VPP], p_susp, err_q[SB_LOCK], 1'b0};

  fsc_op_timer #(.CNT_W(CNT_W), .SUSP_LAT(SUSP_LAT)) u_erase_tmr (
    .clk(clk), .rst(rst), .start(start_e), .load(CNT_W'(ERASE_CYC - 1)),
    .susp_req(sreq_e), .resume(res_e), .busy(e_busy), .can_susp(e_can),
    .susp(e_susp), .tick(e_tick), .cnt(e_cnt)
  );

  fsc_op_timer #(.CNT_W(CNT_W), .SUSP_LAT(SUSP_LAT)) u_prog_tmr (
    .clk(clk), .rst(rst), .start(start_p), .load(CNT_W'(PROG_CYC - 1)),
    .susp_req(sreq_p), .resume(res_p), .busy(p_busy), .can_susp(p_can),
    .susp(p_susp), .tick(p_tick), .cnt(p_cnt)
  );

  // program writes on its last step; erase clears one word per step at the tail
  always_comb begin
    mem_we    = 1'b0;
    mem_waddr = {eblk_q, e_cnt[OFF_W-1:0]};
    mem_wdata = 8'hFF;
    if (p_tick) begin
      mem_we    = (p_cnt == '0);
      mem_waddr = paddr_q;
      mem_wdata = pdata_q;
    end else if (e_tick) begin
      mem_we = (e_cnt < CNT_W'(BLK_WORDS));
    end
  end

  fsc_array #(.AW(ADDR_W), .DW(BYTE_W)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(rd_addr), .rdata(arr_q)
  );

  assign show_sr = mode_sr_q || any_busy ||
                   (p_susp && (rd_addr == paddr_q)) ||
                   (e_susp && (rd_blk == eblk_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      show_q <= 1'b0;
      sr_q   <= 8'h80;
    end else begin
      show_q <= show_sr;
      sr_q   <= sr;
    end
  end

  assign rd_data = show_q ? sr_q : arr_q;
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             sts_oe,
  input logic             e_busy,
  input logic             e_susp,
  input logic             p_busy,
  input logic             p_susp,
  input logic             e_tick,
  input logic             p_tick,
  input logic             res_e,
  input logic             mem_we,
  input logic [CNT_W-1:0] e_cnt
);
  AST_BUSY_DRIVES_STS: assert property (@(posedge clk) disable iff (rst)
    $rose(p_busy) |=> sts_oe);                                         // R2

  AST_ESUSP_RELEASES_STS: assert property (@(posedge clk) disable iff (rst)
    (e_susp && !p_busy && !e_busy) |=> !sts_oe);                       // R4

  AST_PSUSP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    p_susp |-> !mem_we);                                               // R5

  AST_ONE_ENGINE: assert property (@(posedge clk) disable iff (rst)
    !(e_tick && p_tick));                                              // R7

  AST_ERES_HELD: assert property (@(posedge clk) disable iff (rst)
    (p_busy || p_susp) |-> !res_e);                                    // R8

  AST_ERASE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (e_susp && $past(e_susp)) |-> $stable(e_cnt));                     // R9
endmodule

bind flash_susp_ctrl fsc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .sts_oe(sts_oe), .e_busy(e_busy), .e_susp(e_susp),
  .p_busy(p_busy), .p_susp(p_susp), .e_tick(e_tick), .p_tick(p_tick),
  .res_e(res_e), .mem_we(mem_we), .e_cnt(e_cnt)
);

// File: tb/flash_susp_ctrl_tb.sv
module flash_susp_ctrl_tb;
  localparam int AW = 6;
  localparam int BB = 2;
  localparam int PCYC = 8;
  localparam int ECYC = 40;
  localparam int SLAT = 4;
  localparam int NV = 6;
  // {address, data}
  localparam logic [13:0] PVEC [NV] = '{
    {6'd5, 8'h12}, {6'd18, 8'h34}, {6'd30, 8'h56},
    {6'd37, 8'h78}, {6'd63, 8'h9A}, {6'd0, 8'h0F}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_we = 1'b0;
  logic [7:0]    cmd_data = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic          vpp_ok = 1'b1;
  logic          wp_n = 1'b1;
  logic [3:0]    lock_bits = '0;
  logic          sts_oe;

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_mem [64];

  always #2 clk = ~clk;

  flash_susp_ctrl #(.ADDR_W(AW), .BLK_BITS(BB), .PROG_CYC(PCYC),
                    .ERASE_CYC(ECYC), .SUSP_LAT(SLAT)) u_dut (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .cmd_addr(cmd_addr), .rd_addr(rd_addr), .rd_data(rd_data),
    .vpp_ok(vpp_ok), .wp_n(wp_n), .lock_bits(lock_bits), .sts_oe(sts_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_cmd(input logic [7:0] d, input logic [AW-1:0] a);
    @(negedge clk);
    cmd_we = 1'b1; cmd_data = d; cmd_addr = a;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic get_sr(output logic [7:0] v);
    wr_cmd(8'h70, '0);
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic rd_arr(input logic [AW-1:0] a, output logic [7:0] v);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic wait_ready();
    int n = 0;
    do begin @(negedge clk); n++; end while (!rd_data[7] && n < 2000);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int n;
    for (int i = 0; i < 64; i++) exp_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sts_oe == 1'b0, "R1 sts_oe after reset", sts_oe, 0);
    chk(rd_data == 8'hFF, "R1 array mode after reset", rd_data, 8'hFF);
    get_sr(v);
    chk(v == 8'h80, "R1 status after reset", v, 8'h80);

    // R2: vector table of programs
    for (int i = 0; i < NV; i++) begin
      logic [AW-1:0] a;
      logic [7:0]    d;
      a = PVEC[i][13:8];
      d = PVEC[i][7:0];
      wr_cmd(8'h40, '0);
      wr_cmd(d, a);
      exp_mem[a] = d;
      if (i == 0) begin
        n = 0;
        @(negedge clk);
        while (sts_oe && n < 1000) begin n++; @(negedge clk); end
        chk(n == PCYC, "R2 busy length", n, PCYC);
      end else begin
        wait_ready();
      end
      get_sr(v);
      chk(v == 8'h80, "R2 status after program", v, 8'h80);
      wr_cmd(8'hFF, '0);
      rd_arr(a, v);
      chk(v == d, "R2 readback", v, d);
    end

    // R3: erase block 1
    wr_cmd(8'h20, '0);
    wr_cmd(8'hD0, 6'd16);
    for (int i = 16; i < 32; i++) exp_mem[i] = 8'hFF;
    wait_ready();
    wr_cmd(8'hFF, '0);
    rd_arr(6'd18, v); chk(v == 8'hFF, "R3 erased word", v, 8'hFF);
    rd_arr(6'd30, v); chk(v == 8'hFF, "R3 erased word", v, 8'hFF);
    rd_arr(6'd5, v);  chk(v == 8'h12, "R3 other block kept", v, 8'h12);
    rd_arr(6'd37, v); chk(v == 8'h78, "R3 other block kept", v, 8'h78);

    // R4: erase block 2 then suspend
    wr_cmd(8'h20, '0);
    wr_cmd(8'hD0, 6'd32);
    repeat (3) @(negedge clk);
    wr_cmd(8'hB0, '0);
    n = 0;
    while (rd_data != 8'hC0 && n < 100) begin @(negedge clk); n++; end
    chk(n == SLAT + 1, "R4 erase suspend latency", n, SLAT + 1);
    chk(sts_oe == 1'b0, "R4 sts released", sts_oe, 0);

    // R6: allowed commands in erase suspend
    wr_cmd(8'hFF, '0);
    rd_arr(6'd63, v); chk(v == 8'h9A, "R6 read other block", v, 8'h9A);
    rd_arr(6'd37, v); chk(v == 8'hC0, "R6 suspended block gives status", v, 8'hC0);
    wr_cmd(8'h20, '0);
    get_sr(v);
    chk(v == 8'hC0, "R6 erase setup ignored", v, 8'hC0);
    wr_cmd(8'h40, '0);
    wr_cmd(8'h55, 6'd40);
    @(negedge clk);
    chk(rd_data == 8'hC0, "R6 program to suspended block dropped", rd_data, 8'hC0);
    chk(sts_oe == 1'b0, "R6 no busy after dropped program", sts_oe, 0);

    // R7/R8: nested program, erase resume held
    wr_cmd(8'h40, '0);
    wr_cmd(8'h5A, 6'd10);
    exp_mem[10] = 8'h5A;
    @(negedge clk);
    chk(rd_data == 8'h40, "R7 nested program status", rd_data, 8'h40);
    wr_cmd(8'hD0, '0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(rd_data == 8'h40, "R8 erase resume held", rd_data, 8'h40);
    end
    n = 0;
    while (rd_data[6] && n < 200) begin @(negedge clk); n++; end
    chk(rd_data == 8'h00, "R9 erase resumed status", rd_data, 8'h00);
    chk(sts_oe == 1'b1, "R9 sts driven after resume", sts_oe, 1);
    for (int i = 32; i < 48; i++) exp_mem[i] = 8'hFF;
    wait_ready();
    get_sr(v);
    chk(v == 8'h80, "R9 status after erase", v, 8'h80);
    wr_cmd(8'hFF, '0);
    rd_arr(6'd10, v); chk(v == 8'h5A, "R8 nested program written", v, 8'h5A);
    for (int i = 32; i < 48; i += 5) begin
      rd_arr(6'(i), v);
      chk(v == 8'hFF, "R9 resumed erase complete", v, 8'hFF);
    end

    // R5/R10: program suspend
    wr_cmd(8'h40, '0);
    wr_cmd(8'h33, 6'd50);
    exp_mem[50] = 8'h33;
    wr_cmd(8'hB0, '0);
    n = 0;
    while (rd_data != 8'h84 && n < 100) begin @(negedge clk); n++; end
    chk(n == SLAT + 1, "R5 program suspend latency", n, SLAT + 1);
    wr_cmd(8'hFF, '0);
    rd_arr(6'd63, v); chk(v == 8'h9A, "R10 read elsewhere", v, 8'h9A);
    rd_arr(6'd50, v); chk(v == 8'h84, "R10 suspended address gives status", v, 8'h84);
    wr_cmd(8'h20, '0);
    get_sr(v);
    chk(v == 8'h84, "R10 erase setup ignored", v, 8'h84);
    wr_cmd(8'hD0, '0);
    @(negedge clk);
    chk(rd_data == 8'h00, "R9 program resume clears bits", rd_data, 8'h00);
    wait_ready();
    wr_cmd(8'hFF, '0);
    rd_arr(6'd50, v); chk(v == 8'h33, "R5 program done after resume", v, 8'h33);

    // R11: supply low
    vpp_ok = 1'b0;
    wr_cmd(8'h40, '0);
    wr_cmd(8'h00, 6'd3);
    get_sr(v);
    chk(v == 8'h98, "R11 supply error", v, 8'h98);
    vpp_ok = 1'b1;
    wr_cmd(8'hFF, '0);
    rd_arr(6'd3, v); chk(v == exp_mem[3], "R11 array unchanged", v, exp_mem[3]);
    wr_cmd(8'h50, '0);
    get_sr(v);
    chk(v == 8'h80, "R13 clear after supply error", v, 8'h80);

    // R12: lock with write protect
    lock_bits = 4'b1000;
    wp_n = 1'b0;
    wr_cmd(8'h40, '0);
    wr_cmd(8'h11, 6'd60);
    get_sr(v);
    chk(v == 8'h92, "R12 locked program", v, 8'h92);
    wr_cmd(8'h50, '0);
    wr_cmd(8'h20, '0);
    wr_cmd(8'hD0, 6'd48);
    get_sr(v);
    chk(v == 8'h92, "R12 locked erase", v, 8'h92);
    wr_cmd(8'hFF, '0);
    rd_arr(6'd63, v); chk(v == 8'h9A, "R12 locked block kept", v, 8'h9A);
    rd_arr(6'd60, v); chk(v == 8'hFF, "R12 locked word kept", v, 8'hFF);
    wr_cmd(8'h50, '0);
    get_sr(v);
    chk(v == 8'h80, "R13 clear after lock error", v, 8'h80);
    wp_n = 1'b1;
    wr_cmd(8'h40, '0);
    wr_cmd(8'h11, 6'd60);
    wait_ready();
    wr_cmd(8'hFF, '0);
    rd_arr(6'd60, v); chk(v == 8'h11, "R12 unprotected program", v, 8'h11);
    lock_bits = '0;

    // R14: bad erase sequence
    wr_cmd(8'h20, '0);
    wr_cmd(8'h40, '0);
    get_sr(v);
    chk(v == 8'hB0, "R14 sequence error", v, 8'hB0);
    wr_cmd(8'h50, '0);
    get_sr(v);
    chk(v == 8'h80, "R13 clear after sequence error", v, 8'h80);

    finish_run();
  end
endmodule